// File: doc/BRIEF.md
# Sector Programming Sequencer

This block is the host-side controller that rewrites one whole sector of a byte-wide, sector-write non-volatile memory over an asynchronous SRAM-style strobe bus (chip enable, write enable, output enable, all active low). A caller pulses a start request with a sector number and then streams the sector's bytes over a ready/valid handshake. The sequencer first issues a fixed three-write unlock preamble. It then writes every byte of the sector at rising in-sector addresses. Finally it stays off the bus for the device's write cycle time and reports completion.

The same engine also runs the identification sequence. It issues a different three-write preamble, waits the cycle time, reads address zero and returns that byte as the manufacturer code. Strobe width and the cycle-time wait are clock counts set by parameters, so the block can be retimed for another clock or device family without changes to the logic.

States of the control machine: ST_IDLE (waits for start), ST_KEY1, ST_KEY2 and ST_KEY3 (the three preamble writes), ST_LOAD (data bytes), ST_SETTLE (cycle-time wait), ST_PROBE (identification read) and ST_DONE (one-cycle completion). Transitions: ST_IDLE to ST_KEY1 on start. Each ST_KEYn moves to the next key state when its bus cycle ends. ST_KEY3 moves to ST_LOAD for programming or to ST_SETTLE for identification. ST_LOAD moves to ST_SETTLE when the write of byte 511 ends. ST_SETTLE moves to ST_DONE for programming or to ST_PROBE for identification when the wait expires. ST_PROBE moves to ST_DONE when the read ends. ST_DONE returns to ST_IDLE.

Top module: `sector_prog_seq`

## Requirements
- R1: Out of reset, busy, done and ready are low and chip enable, write enable and output enable are all high. While not busy, all three strobes stay high.
- R2: A programming operation begins with exactly three bus writes in this order: AAh to address 5555h, then 55h to address 2AAAh, then A0h to address 5555h. These come before any data write.
- R3: After the preamble, exactly 512 data writes follow. Write i carries address bits 18..9 equal to the sector number latched at start and bits 8..0 equal to i, for i from 0 to 511 in order. Its data is the i-th byte accepted on the stream.
- R4: After the last data write ends, no strobe is asserted for at least TWC_CLKS clocks, and done rises no later than two clocks beyond that.
- R5: Every bus write holds chip enable and write enable low together for exactly STROBE_CLKS clocks. Output enable stays high during it, and address and write data do not change while write enable is low.
- R6: Busy rises on the clock after an accepted start and stays high through the single-cycle done pulse. Busy and done are both low on the following clock.
- R7: A start request that arrives while busy is ignored. The running operation keeps its sector and mode, and no new operation follows its done.
- R8: Ready is high only in the data phase when no bus cycle is in flight. While the stream withholds valid, no bus write is issued and the byte index does not advance.
- R9: An identification operation (mode input high at start) writes AAh to 5555h, 55h to 2AAAh and 90h to 5555h. It then asserts no strobe for at least TWC_CLKS clocks, reads address 0 with chip enable and output enable low and write enable high, and presents the byte read on the code output by the time done pulses.
- R10: The mode input is sampled only with an accepted start. Changing it while busy does not alter the third preamble byte or the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| ident_i | input | 1 | Mode at start: 1 identification, 0 programming |
| sector_i | input | SECTOR_W | Sector number, sampled with start |
| wr_byte_i | input | 8 | Stream data byte |
| wr_valid_i | input | 1 | Stream byte valid |
| wr_ready_o | output | 1 | Sequencer can accept a stream byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| maker_code_o | output | 8 | Byte read by the last identification |
| mem_addr_o | output | SECTOR_W+BYTE_BITS | Memory address bus |
| mem_dq_o | output | 8 | Memory write data |
| mem_dq_i | input | 8 | Memory read data |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
A control state that skips or repeats shows at the memory bus within one bus cycle, as a wrong preamble address or byte, a missing or extra data write, or a count other than 515 writes. A byte index that drifts, or a sector latched at the wrong time, shows in the address of the very next write. A wait counter that is off by a cycle shows in the distance from the last write strobe to done or to the identification read. A strobe sequencer with a wrong count shows in the pulse width of every single write.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int BYTE_W = 8;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_IDENT  = 8'h90;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_LOAD,
        ST_SETTLE,
        ST_PROBE,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_t;

endpackage

// File: rtl/sps_bus_cycle.sv
module sps_bus_cycle
    import sps_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int STROBE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              is_read_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              idle_o,
    output logic              ack_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BYTE_W-1:0] bus_dq_o,
    input  logic [BYTE_W-1:0] bus_dq_i,
    output logic              bus_dq_oe_o,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              oe_n_o
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;

    bus_phase_t        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] rdata_q;

    // Phase register: setup (1 clk), strobe (STROBE_CLKS), hold (1 clk)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        phase_q <= PH_SETUP;
                        addr_q  <= addr_i;
                        data_q  <= wdata_i;
                        rd_q    <= is_read_i;
                    end
                end
                PH_SETUP: begin
                    phase_q <= PH_STROBE;
                    cnt_q   <= '0;
                end
                PH_STROBE: begin
                    if (cnt_q == CNT_W'(STROBE_CLKS - 1)) begin
                        phase_q <= PH_HOLD;
                        if (rd_q) begin
                            rdata_q <= bus_dq_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_HOLD: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        idle_o      = (phase_q == PH_IDLE);
        ack_o       = (phase_q == PH_HOLD);
        ce_n_o      = !(phase_q == PH_STROBE);
        we_n_o      = !((phase_q == PH_STROBE) && !rd_q);
        oe_n_o      = !((phase_q == PH_STROBE) && rd_q);
        bus_dq_oe_o = (phase_q != PH_IDLE) && !rd_q;
        bus_addr_o  = addr_q;
        bus_dq_o    = data_q;
        rdata_o     = rdata_q;
    end

endmodule

// File: rtl/sps_cycle_timer.sv
module sps_cycle_timer #(
    parameter int TWC_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expire_o
);

    localparam int CW = (TWC_CLKS > 1) ? $clog2(TWC_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire_o = en_i && (cnt_q == CW'(TWC_CLKS - 1));

endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
    import sps_pkg::*;
#(
    parameter int  SECTOR_W    = 10,
    parameter int  BYTE_BITS   = 9,
    parameter int  STROBE_CLKS = 3,
    parameter int  TWC_CLKS    = 500000,
    localparam int ADDR_W      = SECTOR_W + BYTE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                ident_i,
    input  logic [SECTOR_W-1:0] sector_i,
    input  logic [7:0]          wr_byte_i,
    input  logic                wr_valid_i,
    output logic                wr_ready_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [7:0]          maker_code_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [7:0]          mem_dq_o,
    input  logic [7:0]          mem_dq_i,
    output logic                mem_dq_oe_o,
    output logic                mem_ce_n_o,
    output logic                mem_we_n_o,
    output logic                mem_oe_n_o
);

    seq_state_t state_q, state_d;
    logic                 ident_q;
    logic [SECTOR_W-1:0]  sector_q;
    logic [BYTE_BITS-1:0] idx_q;
    logic [7:0]           code_q;

    logic              bus_req, bus_rd, bus_idle, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              timer_en, timer_done;
    logic              last_byte;

    assign last_byte = (idx_q == {BYTE_BITS{1'b1}});

    sps_bus_cycle #(
        .ADDR_W      (ADDR_W),
        .STROBE_CLKS (STROBE_CLKS)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req),
        .is_read_i   (bus_rd),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .idle_o      (bus_idle),
        .ack_o       (bus_ack),
        .rdata_o     (bus_rdata),
        .bus_addr_o  (mem_addr_o),
        .bus_dq_o    (mem_dq_o),
        .bus_dq_i    (mem_dq_i),
        .bus_dq_oe_o (mem_dq_oe_o),
        .ce_n_o      (mem_ce_n_o),
        .we_n_o      (mem_we_n_o),
        .oe_n_o      (mem_oe_n_o)
    );

    sps_cycle_timer #(
        .TWC_CLKS (TWC_CLKS)
    ) u_twc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (timer_en),
        .expire_o (timer_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_KEY1;
            ST_KEY1:   if (bus_ack)    state_d = ST_KEY2;
            ST_KEY2:   if (bus_ack)    state_d = ST_KEY3;
            ST_KEY3:   if (bus_ack)    state_d = ident_q ? ST_SETTLE : ST_LOAD;
            ST_LOAD:   if (bus_ack && last_byte) state_d = ST_SETTLE;
            ST_SETTLE: if (timer_done) state_d = ident_q ? ST_PROBE : ST_DONE;
            ST_PROBE:  if (bus_ack)    state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
        endcase
    end

    // State register and operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ident_q  <= 1'b0;
            sector_q <= '0;
            idx_q    <= '0;
            code_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                ident_q  <= ident_i;
                sector_q <= sector_i;
                idx_q    <= '0;
            end
            if (state_q == ST_LOAD && bus_ack) begin
                idx_q <= idx_q + BYTE_BITS'(1);
            end
            if (state_q == ST_PROBE && bus_ack) begin
                code_q <= bus_rdata;
            end
        end
    end

    // Outputs per state
    always_comb begin
        bus_req    = 1'b0;
        bus_rd     = 1'b0;
        bus_addr   = '0;
        bus_wdata  = '0;
        wr_ready_o = 1'b0;
        timer_en   = 1'b0;
        done_o     = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_KEY1: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(KEY_ADDR_A);
                bus_wdata = KEY_BYTE_A;
            end
            ST_KEY2: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(KEY_ADDR_B);
                bus_wdata = KEY_BYTE_B;
            end
            ST_KEY3: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(KEY_ADDR_A);
                bus_wdata = ident_q ? CMD_IDENT : CMD_PROG;
            end
            ST_LOAD: begin
                bus_req    = wr_valid_i;
                bus_addr   = {sector_q, idx_q};
                bus_wdata  = wr_byte_i;
                wr_ready_o = bus_idle;
            end
            ST_SETTLE: timer_en = 1'b1;
            ST_PROBE: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
        endcase
    end

    assign maker_code_o = code_q;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ready,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n && we_n && oe_n)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n)); // R5

    AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !ce_n); // R5

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq))); // R5

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R6

    AST_READY_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (busy && ce_n)); // R8

endmodule

bind sector_prog_seq sps_checker #(.ADDR_W(ADDR_W)) u_sps_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_o),
    .done  (done_o),
    .ready (wr_ready_o),
    .ce_n  (mem_ce_n_o),
    .we_n  (mem_we_n_o),
    .oe_n  (mem_oe_n_o),
    .addr  (mem_addr_o),
    .dq    (mem_dq_o)
);

// File: tb/tb_sector_prog_seq.sv
module tb_sector_prog_seq;

    localparam int STB = 3;
    localparam int TWC = 40;
    localparam int AW  = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          ident_i = 1'b0;
    logic [9:0]    sector_i = '0;
    logic [7:0]    wr_byte_i = '0;
    logic          wr_valid_i = 1'b0;
    logic          wr_ready_o, busy_o, done_o;
    logic [7:0]    maker_code_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_dq_o, mem_dq_i;
    logic          mem_dq_oe_o, mem_ce_n_o, mem_we_n_o, mem_oe_n_o;
    logic [7:0]    mfr_code = 8'h1F;

    always #10ns clk = ~clk;

    assign mem_dq_i = (mem_addr_o == '0) ? mfr_code : ~mfr_code;

    sector_prog_seq #(
        .SECTOR_W (10), .BYTE_BITS (9), .STROBE_CLKS (STB), .TWC_CLKS (TWC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .ident_i (ident_i),
        .sector_i (sector_i), .wr_byte_i (wr_byte_i), .wr_valid_i (wr_valid_i),
        .wr_ready_o (wr_ready_o), .busy_o (busy_o), .done_o (done_o),
        .maker_code_o (maker_code_o), .mem_addr_o (mem_addr_o), .mem_dq_o (mem_dq_o),
        .mem_dq_i (mem_dq_i), .mem_dq_oe_o (mem_dq_oe_o), .mem_ce_n_o (mem_ce_n_o),
        .mem_we_n_o (mem_we_n_o), .mem_oe_n_o (mem_oe_n_o)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [9:0] sec, input int i);
        return {sec, 9'(i)};
    endfunction

    // Bus monitor
    logic [AW-1:0] wr_addr [0:599];
    logic [7:0]    wr_data [0:599];
    int n_wr = 0, n_rd = 0, cyc = 0, rise_cyc = 0, rd_cyc = 0, done_cyc = 0;
    logic [AW-1:0] rd_addr = '0, low_addr = '0;
    logic [7:0]    low_data = '0;
    int low_cnt = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_we_n_o) begin
                if (prev_we) begin
                    low_cnt = 1; low_addr = mem_addr_o; low_data = mem_dq_o;
                end else begin
                    low_cnt++;
                    check(mem_addr_o == low_addr && mem_dq_o == low_data, "R5",
                          "address/data held during write", mem_addr_o, low_addr);
                end
                check(!mem_ce_n_o && mem_oe_n_o, "R5", "ce low and oe high in write",
                      {mem_ce_n_o, mem_oe_n_o}, 2'b01);
            end else if (!prev_we) begin
                check(low_cnt == STB, "R5", "write strobe width", low_cnt, STB);
                if (n_wr < 600) begin
                    wr_addr[n_wr] = low_addr; wr_data[n_wr] = low_data;
                end
                n_wr++;
                rise_cyc = cyc;
            end
            if (!mem_oe_n_o && prev_oe) begin
                n_rd++; rd_addr = mem_addr_o; rd_cyc = cyc;
                check(mem_we_n_o && !mem_ce_n_o, "R9", "read strobes",
                      {mem_we_n_o, mem_ce_n_o}, 2'b10);
            end
            if (done_o) done_cyc = cyc;
            prev_we = mem_we_n_o;
            prev_oe = mem_oe_n_o;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1ns;
    endtask

    task automatic check_preamble(input logic [7:0] cmd, input string req);
        check(wr_addr[0] == 19'h05555 && wr_data[0] == 8'hAA, req, "key write 1",
              {wr_addr[0], wr_data[0]}, {19'h05555, 8'hAA});
        check(wr_addr[1] == 19'h02AAA && wr_data[1] == 8'h55, req, "key write 2",
              {wr_addr[1], wr_data[1]}, {19'h02AAA, 8'h55});
        check(wr_addr[2] == 19'h05555 && wr_data[2] == cmd, req, "key write 3",
              {wr_addr[2], wr_data[2]}, {19'h05555, cmd});
    endtask

    logic [7:0] exp_data [0:511];

    task automatic run_prog(input logic [9:0] sec, input bit stall_dir, input bit poke);
        int idx = 0; bit pend = 0; int stall_left = 0; bit stalled = 0;
        int snap = 0; int guard = 0; int busy_drop = 0; bit poked = 0;
        for (int i = 0; i < 512; i++) exp_data[i] = 8'($urandom);
        n_wr = 0; n_rd = 0;
        start_i = 1'b1; ident_i = 1'b0; sector_i = sec;
        tick();
        start_i = 1'b0;
        ident_i = 1'($urandom);
        sector_i = 10'($urandom);
        check(busy_o, "R6", "busy after start", busy_o, 1);
        while (!done_o && guard < 20000) begin
            guard++;
            if (pend) begin idx++; pend = 0; end
            if (poke && idx == 200 && !poked) begin
                start_i = 1'b1; ident_i = 1'b1; sector_i = ~sec; poked = 1;
            end else start_i = 1'b0;
            if (stall_dir && idx == 100 && !stalled) begin stall_left = 25; stalled = 1; end
            if (stall_left > 0) begin
                wr_valid_i = 1'b0;
                stall_left--;
                if (stall_left == 19) snap = n_wr;
                if (stall_left == 0) begin
                    check(n_wr == snap, "R8", "no write during stall", n_wr, snap);
                    check(wr_ready_o, "R8", "ready while waiting for data", wr_ready_o, 1);
                end
            end else if (idx < 512) begin
                wr_valid_i = ($urandom % 4) != 0;
                wr_byte_i  = exp_data[idx];
            end else wr_valid_i = 1'b0;
            pend = wr_valid_i && wr_ready_o;
            if (!busy_o) busy_drop++;
            tick();
        end
        wr_valid_i = 1'b0;
        start_i = 1'b0;
        check(done_o, "R6", "done reached", done_o, 1);
        check(busy_drop == 0, "R6", "busy held until done", busy_drop, 0);
        check(done_cyc - rise_cyc >= TWC && done_cyc - rise_cyc <= TWC + 2, "R4",
              "quiet clocks before done", done_cyc - rise_cyc, TWC + 1);
        tick();
        check(!busy_o && !done_o, "R6", "busy/done low after done", {busy_o, done_o}, 0);
        repeat (10) tick();
        check(n_wr == 515 && !busy_o, "R7", "no extra operation after done", n_wr, 515);
        check(n_wr == 515, "R3", "total write count", n_wr, 515);
        check_preamble(8'hA0, "R2");
        check(wr_data[2] == 8'hA0, "R10", "mode fixed at start", wr_data[2], 8'hA0);
        for (int i = 0; i < 512; i++) begin
            check(wr_addr[3 + i] == exp_addr(sec, i) && wr_data[3 + i] == exp_data[i], "R3",
                  "data write", {wr_addr[3 + i], wr_data[3 + i]}, {exp_addr(sec, i), exp_data[i]});
        end
    endtask

    task automatic run_ident();
        int guard = 0;
        mfr_code = 8'($urandom);
        n_wr = 0; n_rd = 0;
        start_i = 1'b1; ident_i = 1'b1; sector_i = 10'($urandom);
        tick();
        start_i = 1'b0;
        ident_i = 1'b0;
        while (!done_o && guard < 2000) begin guard++; tick(); end
        check(done_o, "R9", "identification done", done_o, 1);
        check(n_wr == 3, "R9", "identification write count", n_wr, 3);
        check_preamble(8'h90, "R9");
        check(n_rd == 1 && rd_addr == '0, "R9", "read of address 0", rd_addr, 0);
        check(rd_cyc - rise_cyc >= TWC, "R9", "wait before read", rd_cyc - rise_cyc, TWC);
        check(maker_code_o == mfr_code, "R9", "manufacturer code", maker_code_o, mfr_code);
        tick();
        check(!busy_o, "R6", "idle after identification", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) tick();
        check(!busy_o && !done_o && !wr_ready_o, "R1", "status low in reset",
              {busy_o, done_o, wr_ready_o}, 0);
        check(mem_ce_n_o && mem_we_n_o && mem_oe_n_o, "R1", "strobes high in reset",
              {mem_ce_n_o, mem_we_n_o, mem_oe_n_o}, 3'b111);
        rst_n = 1'b1;
        repeat (2) tick();
        check(mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !busy_o, "R1", "idle after reset",
              {mem_ce_n_o, mem_we_n_o, mem_oe_n_o}, 3'b111);
        run_prog(10'h000, 1'b1, 1'b0);
        run_prog(10'h3FF, 1'b0, 1'b1);
        run_ident();
        run_prog(10'($urandom), 1'b0, 1'b0);
        run_ident();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule